// File: doc/BRIEF.md
# Execute Stage with Branch Resolution

This block is the combinational execute step of a single-cycle 32-bit RISC-V integer core. It takes the fetched instruction word, that instruction's address, the two register-file read values, the immediate from the decoder, and two operand-source selects. From these it produces the ALU result. In the same cycle it tells the fetch stage whether control flow is redirected, and to which address.

The ALU handles addition, subtraction, shifts, signed and unsigned set-less-than, and the three bitwise operations. The opcode and the function fields of the instruction word choose the operation. A conditional branch always compares the raw register values, whatever the operand selects say. The target address is always formed, even when the branch is not taken, so the target port holds a meaningful value every cycle.

The block holds no state and has no handshake. Results are valid in the cycle their inputs are valid, and any stall or back-pressure belongs to the surrounding core: holding the inputs holds the outputs.

Top module: `exec_unit`

## Requirements
- R1: The first ALU operand is `rs1_val` when `op1_sel` is 1 and `pc_in` when it is 0. The second ALU operand is `rs2_val` when `op2_sel` is 1 and `imm_in` when it is 0.
- R2: For a register-register instruction (opcode bits [6:0] = 0110011) with funct3 (bits [14:12]) = 000, `alu_out` is the sum modulo 2^32 when bit 30 is 0 and operand1 minus operand2 when bit 30 is 1.
- R3: funct3 001 shifts left, and funct3 101 shifts right. The right shift is arithmetic when bit 30 is 1 and logical when it is 0. Only the low 5 bits of operand2 are used as the shift amount.
- R4: funct3 010 gives 1 if operand1 < operand2 as signed values, and 0 otherwise. funct3 011 does the same with unsigned values.
- R5: funct3 100, 110 and 111 give XOR, OR and AND respectively.
- R6: For a register-immediate instruction (opcode 0010011) the same funct3 mapping applies. Bit 30 has an effect only for funct3 101, and an add is never turned into a subtract.
- R7: For a conditional branch (opcode 1100011), funct3 000 sets `jump_taken` when `rs1_val` equals `rs2_val`, and funct3 001 sets it when they differ.
- R8: Branch funct3 100, 101, 110 and 111 are taken on signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal of `rs1_val` against `rs2_val`. These compares use the raw register values regardless of the operand selects.
- R9: For every opcode other than 1100111, `jump_target` equals `pc_in + imm_in` modulo 2^32, whether or not the jump is taken.
- R10: Opcode 1101111 is always taken. Opcode 1100111 is always taken, with target (`rs1_val + imm_in`) and bit 0 forced to 0.
- R11: `jump_taken` is 0 for every opcode other than the three control-flow opcodes, and also for branch funct3 010 and 011.
- R12: For every opcode other than 0110011 and 0010011, `alu_out` is operand1 plus operand2, whatever the funct3 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| pc_in | input | 32 | Address of that instruction |
| rs1_val | input | 32 | First register read value |
| rs2_val | input | 32 | Second register read value |
| imm_in | input | 32 | Decoded, sign-extended immediate |
| op1_sel | input | 1 | Operand1 source: 1 register, 0 instruction address |
| op2_sel | input | 1 | Operand2 source: 1 register, 0 immediate |
| alu_out | output | 32 | ALU result |
| jump_taken | output | 1 | Redirect request to fetch |
| jump_target | output | 32 | Redirect address for fetch |

## Verification
The block holds no state, so any fault shows at the ports in the same evaluation as the inputs that expose it. Nothing is hidden for later cycles. A wrong operation decode shows as a wrong `alu_out` only for the specific funct3/bit-30 patterns that reach the faulty path, so the vectors cover every encoding, including sign boundary values. A mistake in the branch compare or the target adder shows on `jump_taken` or `jump_target` immediately. For that reason the target is checked on not-taken branches too, and compares are driven with operand selects that point away from the registers.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_BR   = 7'b1100011;
  localparam logic [6:0] OPC_JAL  = 7'b1101111;
  localparam logic [6:0] OPC_JALR = 7'b1100111;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;
endpackage

// File: rtl/exec_alu_ctrl.sv
module exec_alu_ctrl
  import exec_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic       alt_bit,
  output alu_op_e    alu_op
);
  logic is_reg, is_arith;

  assign is_reg   = (opcode == OPC_REG);
  assign is_arith = is_reg || (opcode == OPC_IMM);

  always_comb begin
    alu_op = ALU_ADD;
    if (is_arith) begin
      unique case (funct3)
        3'b000:  alu_op = (is_reg && alt_bit) ? ALU_SUB : ALU_ADD;
        3'b001:  alu_op = ALU_SLL;
        3'b010:  alu_op = ALU_SLT;
        3'b011:  alu_op = ALU_SLTU;
        3'b100:  alu_op = ALU_XOR;
        3'b101:  alu_op = alt_bit ? ALU_SRA : ALU_SRL;
        3'b110:  alu_op = ALU_OR;
        default: alu_op = ALU_AND;
      endcase
    end
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         alu_op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] res
);
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] shamt;
  assign shamt = opb[SHW-1:0];

  always_comb begin
    unique case (alu_op)
      ALU_SUB:  res = opa - opb;
      ALU_SLL:  res = opa << shamt;
      ALU_SLT:  res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
      ALU_SLTU: res = {{(XLEN-1){1'b0}}, (opa < opb)};
      ALU_XOR:  res = opa ^ opb;
      ALU_SRL:  res = opa >> shamt;
      ALU_SRA:  res = $unsigned($signed(opa) >>> shamt);
      ALU_OR:   res = opa | opb;
      ALU_AND:  res = opa & opb;
      default:  res = opa + opb;
    endcase
  end
endmodule

// File: rtl/exec_branch.sv
module exec_branch
  import exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [6:0]      opcode,
  input  logic [2:0]      funct3,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] imm,
  output logic            taken,
  output logic [XLEN-1:0] target
);
  logic eq, lts, ltu, cond;
  logic [XLEN-1:0] reg_sum;

  assign eq      = (src_a == src_b);
  assign lts     = ($signed(src_a) < $signed(src_b));
  assign ltu     = (src_a < src_b);
  assign reg_sum = src_a + imm;

  always_comb begin
    unique case (funct3)
      3'b000:  cond = eq;
      3'b001:  cond = !eq;
      3'b100:  cond = lts;
      3'b101:  cond = !lts;
      3'b110:  cond = ltu;
      3'b111:  cond = !ltu;
      default: cond = 1'b0;
    endcase
  end

  always_comb begin
    taken  = 1'b0;
    target = pc + imm;
    if (opcode == OPC_BR) begin
      taken = cond;
    end else if (opcode == OPC_JAL) begin
      taken = 1'b1;
    end else if (opcode == OPC_JALR) begin
      taken  = 1'b1;
      target = {reg_sum[XLEN-1:1], 1'b0};
    end
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm_in,
  input  logic            op1_sel,
  input  logic            op2_sel,
  output logic [XLEN-1:0] alu_out,
  output logic            jump_taken,
  output logic [XLEN-1:0] jump_target
);
  logic [6:0]      opcode;
  logic [2:0]      funct3;
  logic            alt_bit;
  logic [XLEN-1:0] opa, opb;
  alu_op_e         alu_op;

  assign opcode  = instr[6:0];
  assign funct3  = instr[14:12];
  assign alt_bit = instr[30];
  assign opa     = op1_sel ? rs1_val : pc_in;
  assign opb     = op2_sel ? rs2_val : imm_in;

  exec_alu_ctrl ctrl_i (
    .opcode (opcode),
    .funct3 (funct3),
    .alt_bit(alt_bit),
    .alu_op (alu_op)
  );

  exec_alu #(.XLEN(XLEN)) alu_i (
    .alu_op(alu_op),
    .opa   (opa),
    .opb   (opb),
    .res   (alu_out)
  );

  exec_branch #(.XLEN(XLEN)) br_i (
    .opcode(opcode),
    .funct3(funct3),
    .pc    (pc_in),
    .src_a (rs1_val),
    .src_b (rs2_val),
    .imm   (imm_in),
    .taken (jump_taken),
    .target(jump_target)
  );
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk #(
  parameter int XLEN = 32
) (
  input logic [31:0]     instr,
  input logic [XLEN-1:0] pc_in,
  input logic [XLEN-1:0] rs1_val,
  input logic [XLEN-1:0] rs2_val,
  input logic [XLEN-1:0] imm_in,
  input logic            op1_sel,
  input logic            op2_sel,
  input logic [XLEN-1:0] alu_out,
  input logic            jump_taken,
  input logic [XLEN-1:0] jump_target
);
  logic is_ctl;
  logic known;
  assign is_ctl = (instr[6:0] == 7'b1100011) || (instr[6:0] == 7'b1101111) ||
                  (instr[6:0] == 7'b1100111);
  assign known  = !$isunknown({instr, pc_in, rs1_val, rs2_val, imm_in, op1_sel, op2_sel,
                               alu_out, jump_taken, jump_target});

  always_comb begin
    if (known) begin
      // R9
      target_sum_chk: assert ((instr[6:0] == 7'b1100111) || (jump_target == pc_in + imm_in));
      // R11
      no_redirect_chk: assert (is_ctl || !jump_taken);
      // R10
      jal_taken_chk: assert ((instr[6:0] != 7'b1101111) || jump_taken);
      // R10
      jalr_align_chk: assert ((instr[6:0] != 7'b1100111) || (jump_taken && !jump_target[0]));
      // R7
      beq_cmp_chk: assert (!((instr[6:0] == 7'b1100011) && (instr[14:12] == 3'b000)) ||
                           (jump_taken == (rs1_val == rs2_val)));
    end
  end
endmodule

bind exec_unit exec_unit_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/exec_unit_tb_top.sv
module exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 30;

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] pc;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] im;
    logic        s1;
    logic        s2;
    logic [31:0] res;
    logic        fl;
    logic [31:0] tg;
    logic [7:0]  rq;
  } vec_t;

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                     input logic [6:0] op);
    return {f7, 5'd2, 5'd1, f3, 5'd3, op};
  endfunction

  localparam vec_t VECS [NVEC] = '{
    // R2 add, R1 register operands
    '{32'h001101b3, 32'h1000, 32'd100, 32'd23, 32'd8, 1'b1, 1'b1, 32'd123, 1'b0, 32'h1008, 8'd2},
    // R2 subtract wraps
    '{mk(7'h20, 3'd0, 7'h33), 32'h0, 32'd5, 32'd7, 32'd0, 1'b1, 1'b1, 32'hFFFFFFFE, 1'b0, 32'h0, 8'd2},
    // R1 address and immediate operands
    '{mk(7'h00, 3'd0, 7'h33), 32'h1000, 32'd1, 32'd2, 32'h10, 1'b0, 1'b0, 32'h1010, 1'b0, 32'h1010, 8'd1},
    // R1 mixed selects
    '{mk(7'h00, 3'd0, 7'h33), 32'h1000, 32'd1, 32'd2, 32'h10, 1'b1, 1'b0, 32'h11, 1'b0, 32'h1010, 8'd1},
    // R3 left shift uses low 5 bits
    '{mk(7'h00, 3'd1, 7'h33), 32'h0, 32'd1, 32'h24, 32'd0, 1'b1, 1'b1, 32'h10, 1'b0, 32'h0, 8'd3},
    // R3 arithmetic right
    '{mk(7'h20, 3'd5, 7'h33), 32'h0, 32'h80000000, 32'd4, 32'd0, 1'b1, 1'b1, 32'hF8000000, 1'b0, 32'h0, 8'd3},
    // R3 logical right
    '{mk(7'h00, 3'd5, 7'h33), 32'h0, 32'h80000000, 32'd4, 32'd0, 1'b1, 1'b1, 32'h08000000, 1'b0, 32'h0, 8'd3},
    // R4 signed less
    '{mk(7'h00, 3'd2, 7'h33), 32'h0, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b1, 1'b1, 32'd1, 1'b0, 32'h0, 8'd4},
    // R4 unsigned less
    '{mk(7'h00, 3'd3, 7'h33), 32'h0, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b1, 1'b1, 32'd0, 1'b0, 32'h0, 8'd4},
    // R5 xor
    '{mk(7'h00, 3'd4, 7'h33), 32'h0, 32'hF0F0F0F0, 32'h0FF00FF0, 32'd0, 1'b1, 1'b1, 32'hFF00FF00, 1'b0, 32'h0, 8'd5},
    // R5 or
    '{mk(7'h00, 3'd6, 7'h33), 32'h0, 32'hF0F0F0F0, 32'h0FF00FF0, 32'd0, 1'b1, 1'b1, 32'hFFF0FFF0, 1'b0, 32'h0, 8'd5},
    // R5 and
    '{mk(7'h00, 3'd7, 7'h33), 32'h0, 32'hF0F0F0F0, 32'h0FF00FF0, 32'd0, 1'b1, 1'b1, 32'h00F000F0, 1'b0, 32'h0, 8'd5},
    // R6 immediate add ignores bit 30
    '{mk(7'h20, 3'd0, 7'h13), 32'h0, 32'd10, 32'd99, 32'd3, 1'b1, 1'b0, 32'd13, 1'b0, 32'd3, 8'd6},
    // R6 immediate arithmetic right
    '{mk(7'h20, 3'd5, 7'h13), 32'h0, 32'h80000000, 32'd99, 32'd1, 1'b1, 1'b0, 32'hC0000000, 1'b0, 32'd1, 8'd6},
    // R7 equal taken
    '{32'h00208163, 32'd2, 32'd9, 32'd9, 32'd2, 1'b1, 1'b1, 32'd18, 1'b1, 32'd4, 8'd7},
    // R9 unequal not taken, target still formed
    '{32'h00208163, 32'd2, 32'd9, 32'd19, 32'd2, 1'b1, 1'b1, 32'd28, 1'b0, 32'd4, 8'd9},
    // R7 not-equal taken; R8 raw registers despite selects 0
    '{mk(7'h00, 3'd1, 7'h63), 32'h100, 32'd9, 32'd19, 32'h20, 1'b0, 1'b0, 32'h120, 1'b1, 32'h120, 8'd7},
    // R7 not-equal on equal values
    '{mk(7'h00, 3'd1, 7'h63), 32'h100, 32'd9, 32'd9, 32'h20, 1'b0, 1'b0, 32'h120, 1'b0, 32'h120, 8'd7},
    // R8 signed less taken, negative offset
    '{mk(7'h00, 3'd4, 7'h63), 32'h200, 32'hFFFFFFFF, 32'd1, 32'hFFFFFFF0, 1'b1, 1'b1, 32'd0, 1'b1, 32'h1F0, 8'd8},
    // R8 signed ge not taken
    '{mk(7'h00, 3'd5, 7'h63), 32'h200, 32'hFFFFFFFF, 32'd1, 32'hFFFFFFF0, 1'b1, 1'b1, 32'd0, 1'b0, 32'h1F0, 8'd8},
    // R8 unsigned less not taken
    '{mk(7'h00, 3'd6, 7'h63), 32'h200, 32'hFFFFFFFF, 32'd1, 32'hFFFFFFF0, 1'b1, 1'b1, 32'd0, 1'b0, 32'h1F0, 8'd8},
    // R8 unsigned ge taken
    '{mk(7'h00, 3'd7, 7'h63), 32'h200, 32'hFFFFFFFF, 32'd1, 32'hFFFFFFF0, 1'b1, 1'b1, 32'd0, 1'b1, 32'h1F0, 8'd8},
    // R8 signed ge with equal values taken
    '{mk(7'h00, 3'd5, 7'h63), 32'h200, 32'd5, 32'd5, 32'd8, 1'b0, 1'b0, 32'h208, 1'b1, 32'h208, 8'd8},
    // R11 reserved branch funct3
    '{mk(7'h00, 3'd2, 7'h63), 32'h40, 32'd9, 32'd9, 32'd4, 1'b1, 1'b1, 32'd18, 1'b0, 32'h44, 8'd11},
    // R11 reserved branch funct3 011
    '{mk(7'h00, 3'd3, 7'h63), 32'h40, 32'd9, 32'd9, 32'd4, 1'b1, 1'b1, 32'd18, 1'b0, 32'h44, 8'd11},
    // R10 jump with offset
    '{mk(7'h00, 3'd0, 7'h6F), 32'h300, 32'd0, 32'd0, 32'h40, 1'b0, 1'b0, 32'h340, 1'b1, 32'h340, 8'd10},
    // R10 register jump, bit 0 cleared
    '{mk(7'h00, 3'd0, 7'h67), 32'h500, 32'h1001, 32'd0, 32'd4, 1'b1, 1'b0, 32'h1005, 1'b1, 32'h1004, 8'd10},
    // R10 register jump, odd sum
    '{mk(7'h00, 3'd0, 7'h67), 32'h500, 32'h2000, 32'd0, 32'd7, 1'b1, 1'b0, 32'h2007, 1'b1, 32'h2006, 8'd10},
    // R12 store adds whatever funct3
    '{32'h00a02223, 32'h80, 32'h100, 32'd10, 32'd4, 1'b1, 1'b0, 32'h104, 1'b0, 32'h84, 8'd12},
    // R12 upper-immediate opcode with funct3 101 still adds; R11 no redirect
    '{mk(7'h20, 3'd5, 7'h37), 32'h0, 32'd0, 32'd0, 32'h2000, 1'b1, 1'b0, 32'h2000, 1'b0, 32'h2000, 8'd12}
  };

  logic        clk;
  logic [31:0] instr, pc_in, rs1_val, rs2_val, imm_in;
  logic        op1_sel, op2_sel;
  logic [31:0] alu_out, jump_target;
  logic        jump_taken;
  int          n_run, n_fail;
  bit          done;

  exec_unit dut_i (
    .instr      (instr),
    .pc_in      (pc_in),
    .rs1_val    (rs1_val),
    .rs2_val    (rs2_val),
    .imm_in     (imm_in),
    .op1_sel    (op1_sel),
    .op2_sel    (op2_sel),
    .alu_out    (alu_out),
    .jump_taken (jump_taken),
    .jump_target(jump_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic apply(input vec_t v);
    @(negedge clk);
    instr = v.ins; pc_in = v.pc; rs1_val = v.a; rs2_val = v.b; imm_in = v.im;
    op1_sel = v.s1; op2_sel = v.s2;
    #1;
  endtask

  task automatic check(input vec_t v, input string tag);
    n_run++;
    if (alu_out !== v.res || jump_taken !== v.fl || jump_target !== v.tg) begin
      n_fail++;
      $display("FAIL R%0d %s: got res=%h fl=%b tg=%h exp res=%h fl=%b tg=%h",
               v.rq, tag, alu_out, jump_taken, jump_target, v.res, v.fl, v.tg);
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    // reset-like state: all-zero inputs give opcode 0, an add of zeros (R12)
    apply('{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 8'd12});
    check('{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 8'd12}, "idle");

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      check(VECS[i], "table");
    end

    // R2 random additions with wrap; R9 target follows pc+imm
    for (int i = 0; i < 40; i++) begin
      vec_t v;
      v.ins = 32'h001101b3; v.pc = $urandom; v.a = $urandom; v.b = $urandom;
      v.im = $urandom; v.s1 = 1'b1; v.s2 = 1'b1;
      v.res = v.a + v.b; v.fl = 1'b0; v.tg = v.pc + v.im; v.rq = 8'd2;
      apply(v);
      check(v, "random add");
    end

    // R7 random equal/unequal compares against fixed branch word
    for (int i = 0; i < 20; i++) begin
      vec_t v;
      v.ins = 32'h00208163; v.pc = $urandom; v.a = $urandom;
      v.b = (i % 2 == 0) ? v.a : (v.a ^ 32'h1); v.im = $urandom;
      v.s1 = 1'b0; v.s2 = 1'b0;
      v.res = v.pc + v.im; v.fl = (i % 2 == 0); v.tg = v.pc + v.im; v.rq = 8'd7;
      apply(v);
      check(v, "random branch");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule